// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block decides what a memory access may do once the page-table entry for its address has already been found. It takes the entry's protection and attribute bits, the two key bits of the matching segment, the privilege of the requester, the access kind (instruction fetch, data load or data store) and two per-key authority masks. From these it derives three independent read/write/execute sets and ANDs them: one from a 3-bit protection code, one from the no-execute and guarded attributes, and one from the authority masks. It then reports the combined set, a fault flag, and cause bits shaped either for an instruction-fault status or for a data-fault status.

When the access is granted, the block keeps the entry's usage bits current by issuing single-byte writes into the page table: one that marks the entry as referenced, and, for stores, one that marks it as changed. Each write waits for its own acknowledge. A load or fetch that hits an entry whose changed bit is still clear gets write permission removed from the returned set, so that a later store comes back through this path and sets the changed bit.

The controller is a five-state machine. IDLE raises `req_ready`; a request moves it to EVAL. EVAL registers the result and goes to DONE on a fault, to WR_REF when the referenced bit is clear, to WR_CHG when the access is a store with the changed bit clear, and to DONE otherwise. WR_REF holds its write until acknowledged, then goes to WR_CHG (store with changed bit clear) or DONE. WR_CHG holds its write until acknowledged, then goes to DONE. DONE pulses `res_valid` for one cycle and returns to IDLE.

Top module: `pgperm_eval`

## Requirements
- R1: The key used by the protection code table is `req_seg_kp` when `req_priv` is 0 (unprivileged) and `req_seg_ks` when `req_priv` is 1.
- R2: The protection code is {`req_pp_hi`, `req_ent_low[1:0]`}. With key 0, codes 0, 1 and 2 give read+write+exec, codes 3 and 6 give read+exec, codes 4, 5 and 7 give nothing.
- R3: With key 1, code 2 gives read+write+exec, codes 1 and 3 give read+exec, codes 0, 4, 5, 6 and 7 give nothing.
- R4: If the no-execute bit `req_ent_low[2]` or the guarded bit `req_ent_low[3]` is set, exec is removed; read and write are never removed by this check.
- R5: When `amr_en` is 1, the authority mask field for key k is `amr[2*(NKEYS-1-k)+1 : 2*(NKEYS-1-k)]`; its upper bit removes write and its lower bit removes read. When `amr_en` is 0 the mask removes nothing. Masks are sampled with the request.
- R6: When both `amr_en` and `iamr_en` are 1, bit 0 of the key's field in `iamr` (same position rule as R5) removes exec only.
- R7: `req_acc` encodes 0 fetch, 1 load, 2 store, 3 treated as load. The result set is the AND of the R2/R3, R4 and R5/R6 sets; `res_fault` is 1 when the needed right (exec for fetch, write for store, read otherwise) is missing from it. `res_perm` bits are [2] read, [1] write, [0] exec.
- R8: On a fetch fault, `res_fetch_cause[0]` is set if R4 denied exec, else `res_fetch_cause[1]` is set if the code table denied exec; `res_fetch_cause[2]` is set if the mask denied exec. It is 0 otherwise, and `res_data_cause` is 0 for fetches.
- R9: On a load or store fault, `res_data_cause[0]` is set if the code table lacks the needed right, `[1]` is set for a store, `[2]` is set if the mask lacks the needed right. It is 0 otherwise, and `res_fetch_cause` is 0 for data accesses.
- R10: On a granted access with referenced bit `req_ent_low[8]` clear, a write is issued at address `req_idx*16+16` with data `req_ent_low[15:8] | 8'h01`. No write is issued on a fault.
- R11: On a granted store with changed bit `req_ent_low[7]` clear, a write is issued at `req_idx*16+15` with data `req_ent_low[7:0] | 8'h80`, after the referenced write if that one occurs. Each write holds address and data until `wr_ack`.
- R12: On a granted load or fetch with the changed bit clear, write is removed from `res_perm`.
- R13: After reset `req_ready` is 1 and `res_valid`, `wr_valid` are 0; `req_ready` is 1 only in IDLE; `res_valid` is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_priv | input | 1 | 1 privileged, 0 unprivileged |
| req_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_seg_kp | input | 1 | Segment key bit for unprivileged accesses |
| req_seg_ks | input | 1 | Segment key bit for privileged accesses |
| req_pp_hi | input | 1 | High protection code bit |
| req_ent_low | input | 16 | Low half of entry word: [1:0] code, [2] no-exec, [3] guarded, [7] changed, [8] referenced |
| req_key | input | KEY_W | Entry's authority key number |
| req_idx | input | IDX_W | Entry index in the table |
| amr_en | input | 1 | Authority mask checking enabled |
| iamr_en | input | 1 | Instruction mask checking enabled |
| amr | input | 2*NKEYS | Data authority mask |
| iamr | input | 2*NKEYS | Instruction authority mask |
| res_valid | output | 1 | Result pulse |
| res_perm | output | 3 | Allowed set {read, write, exec} |
| res_fault | output | 1 | Needed right missing |
| res_fetch_cause | output | 3 | Fetch fault cause {key, code, no-exec/guard} |
| res_data_cause | output | 3 | Data fault cause {key, store, code} |
| wr_valid | output | 1 | Byte write request |
| wr_addr | output | IDX_W+5 | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| wr_ack | input | 1 | Write accepted |

## Verification
The bench builds the block with NKEYS=4 and IDX_W=4, so the mask registers shrink to 8 bits and every key's field, and its position, can be exercised against deliberately contrasting neighbour fields. One sweep covers every combination of privilege, both segment key bits, all eight protection codes, all four access kinds, the no-execute and guarded bits, and the referenced and changed bits, with entry index and spare entry bits varying, so every table cell, cause combination and write ordering is compared. A second sweep walks every key, every mask field value, the instruction bit and both enables under each access kind.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_WR_REF,
        ST_WR_CHG,
        ST_DONE
    } state_e;

    // permission vector bit positions
    localparam int P_R = 2;
    localparam int P_W = 1;
    localparam int P_X = 0;

    // entry low-half bit positions
    localparam int ENT_N_BIT = 2;
    localparam int ENT_G_BIT = 3;
    localparam int ENT_C_BIT = 7;
    localparam int ENT_R_BIT = 8;

    // byte offsets of the usage-bit updates relative to idx*16
    localparam logic [4:0] REF_OFS = 5'd16;
    localparam logic [4:0] CHG_OFS = 5'd15;

    typedef struct packed {
        logic        priv;
        acc_e        acc;
        logic        kp;
        logic        ks;
        logic        pp_hi;
        logic [15:0] ent;
    } req_s;

endpackage

// File: rtl/pgperm_code_table.sv
module pgperm_code_table
    import pgperm_pkg::*;
(
    input  logic       key,
    input  logic [2:0] code,
    output logic [2:0] perm
);

    always_comb begin
        perm = 3'b000;
        if (!key) begin
            unique case (code)
                3'd0, 3'd1, 3'd2: perm = 3'b111;
                3'd3, 3'd6:       perm = 3'b101;
                default:          perm = 3'b000;
            endcase
        end else begin
            unique case (code)
                3'd2:       perm = 3'b111;
                3'd1, 3'd3: perm = 3'b101;
                default:    perm = 3'b000;
            endcase
        end
    end

    // write is never granted without read by the table
    always_comb begin
        AST_CODE_W_HAS_R: assert (!(perm[P_W] && !perm[P_R])); // R2
    end

endmodule

// File: rtl/pgperm_key_mask.sv
module pgperm_key_mask
    import pgperm_pkg::*;
#(
    parameter int NKEYS = 32,
    localparam int KEY_W = (NKEYS > 1) ? $clog2(NKEYS) : 1,
    localparam int MASK_W = 2 * NKEYS
) (
    input  logic [KEY_W-1:0]  key,
    input  logic              amr_en,
    input  logic              iamr_en,
    input  logic [MASK_W-1:0] amr,
    input  logic [MASK_W-1:0] iamr,
    output logic [2:0]        perm
);

    logic [1:0] dfield [NKEYS];
    logic [1:0] ifield [NKEYS];

    // key 0 lives in the most significant field
    for (genvar k = 0; k < NKEYS; k++) begin : g_field
        assign dfield[k] = amr[2*(NKEYS-1-k) +: 2];
        assign ifield[k] = iamr[2*(NKEYS-1-k) +: 2];
    end

    logic [1:0] dsel;
    logic [1:0] isel;
    assign dsel = dfield[key];
    assign isel = ifield[key];

    always_comb begin
        perm = 3'b111;
        if (amr_en) begin
            if (dsel[1]) perm[P_W] = 1'b0;
            if (dsel[0]) perm[P_R] = 1'b0;
            if (iamr_en && isel[0]) perm[P_X] = 1'b0;
        end
    end

endmodule

// File: rtl/pgperm_fault_eval.sv
module pgperm_fault_eval
    import pgperm_pkg::*;
(
    input  acc_e       acc,
    input  logic [2:0] code_perm,
    input  logic [2:0] nxg_perm,
    input  logic [2:0] mask_perm,
    output logic [2:0] perm,
    output logic       fault,
    output logic [2:0] fetch_cause,
    output logic [2:0] data_cause
);

    logic [2:0] need;
    logic       code_lack;
    logic       mask_lack;
    logic       nxg_lack;

    always_comb begin
        unique case (acc)
            ACC_FETCH: need = 3'b001;
            ACC_STORE: need = 3'b010;
            default:   need = 3'b100;
        endcase
    end

    assign perm      = code_perm & nxg_perm & mask_perm;
    assign fault     = ~|(perm & need);
    assign code_lack = ~|(code_perm & need);
    assign mask_lack = ~|(mask_perm & need);
    assign nxg_lack  = ~nxg_perm[P_X];

    always_comb begin
        fetch_cause = 3'b000;
        data_cause  = 3'b000;
        if (fault) begin
            if (acc == ACC_FETCH) begin
                fetch_cause[0] = nxg_lack;
                fetch_cause[1] = !nxg_lack && code_lack;
                fetch_cause[2] = mask_lack;
            end else begin
                data_cause[0] = code_lack;
                data_cause[1] = (acc == ACC_STORE);
                data_cause[2] = mask_lack;
            end
        end
    end

endmodule

// File: rtl/pgperm_eval.sv
module pgperm_eval
    import pgperm_pkg::*;
#(
    parameter int NKEYS = 32,
    parameter int IDX_W = 16,
    localparam int KEY_W = (NKEYS > 1) ? $clog2(NKEYS) : 1,
    localparam int MASK_W = 2 * NKEYS,
    localparam int ADDR_W = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_priv,
    input  logic [1:0]        req_acc,
    input  logic              req_seg_kp,
    input  logic              req_seg_ks,
    input  logic              req_pp_hi,
    input  logic [15:0]       req_ent_low,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic              amr_en,
    input  logic              iamr_en,
    input  logic [MASK_W-1:0] amr,
    input  logic [MASK_W-1:0] iamr,
    output logic              res_valid,
    output logic [2:0]        res_perm,
    output logic              res_fault,
    output logic [2:0]        res_fetch_cause,
    output logic [2:0]        res_data_cause,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_ack
);

    state_e state_q, state_d;

    req_s             req_q;
    logic [IDX_W-1:0] idx_q;
    logic [2:0]       mperm_q;

    logic       accept;
    logic [2:0] mperm_live;

    assign accept = req_valid && (state_q == ST_IDLE);

    // mask decision is taken from the live masks at acceptance
    pgperm_key_mask #(.NKEYS(NKEYS)) i_mask (
        .key     (req_key),
        .amr_en  (amr_en),
        .iamr_en (iamr_en),
        .amr     (amr),
        .iamr    (iamr),
        .perm    (mperm_live)
    );

    // evaluation on the registered request
    logic       key_sel;
    logic [2:0] code_perm;
    logic [2:0] nxg_perm;
    logic [2:0] ev_perm;
    logic       ev_fault;
    logic [2:0] ev_fcause;
    logic [2:0] ev_dcause;

    assign key_sel  = req_q.priv ? req_q.ks : req_q.kp;
    assign nxg_perm = (req_q.ent[ENT_N_BIT] || req_q.ent[ENT_G_BIT]) ? 3'b110 : 3'b111;

    pgperm_code_table i_code (
        .key  (key_sel),
        .code ({req_q.pp_hi, req_q.ent[1:0]}),
        .perm (code_perm)
    );

    pgperm_fault_eval i_fault (
        .acc         (req_q.acc),
        .code_perm   (code_perm),
        .nxg_perm    (nxg_perm),
        .mask_perm   (mperm_q),
        .perm        (ev_perm),
        .fault       (ev_fault),
        .fetch_cause (ev_fcause),
        .data_cause  (ev_dcause)
    );

    logic is_store;
    logic ref_clr;
    logic chg_clr;
    assign is_store = (req_q.acc == ACC_STORE);
    assign ref_clr  = !req_q.ent[ENT_R_BIT];
    assign chg_clr  = !req_q.ent[ENT_C_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_EVAL;
            end
            ST_EVAL: begin
                if (ev_fault)                  state_d = ST_DONE;
                else if (ref_clr)              state_d = ST_WR_REF;
                else if (is_store && chg_clr)  state_d = ST_WR_CHG;
                else                           state_d = ST_DONE;
            end
            ST_WR_REF: begin
                if (wr_ack) state_d = (is_store && chg_clr) ? ST_WR_CHG : ST_DONE;
            end
            ST_WR_CHG: begin
                if (wr_ack) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q           <= '0;
            idx_q           <= '0;
            mperm_q         <= '0;
            res_perm        <= '0;
            res_fault       <= 1'b0;
            res_fetch_cause <= '0;
            res_data_cause  <= '0;
        end else begin
            if (accept) begin
                req_q.priv  <= req_priv;
                req_q.acc   <= acc_e'(req_acc);
                req_q.kp    <= req_seg_kp;
                req_q.ks    <= req_seg_ks;
                req_q.pp_hi <= req_pp_hi;
                req_q.ent   <= req_ent_low;
                idx_q       <= req_idx;
                mperm_q     <= mperm_live;
            end
            if (state_q == ST_EVAL) begin
                res_fault       <= ev_fault;
                res_fetch_cause <= ev_fcause;
                res_data_cause  <= ev_dcause;
                if (!ev_fault && !is_store && chg_clr)
                    res_perm <= ev_perm & ~(3'b1 << P_W);
                else
                    res_perm <= ev_perm;
            end
        end
    end

    // outputs
    logic [ADDR_W-1:0] base_addr;
    assign base_addr = {1'b0, idx_q, 4'b0000};

    always_comb begin
        req_ready = 1'b0;
        res_valid = 1'b0;
        wr_valid  = 1'b0;
        wr_addr   = base_addr;
        wr_data   = 8'h00;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_EVAL:   ;
            ST_WR_REF: begin
                wr_valid = 1'b1;
                wr_addr  = base_addr + ADDR_W'(REF_OFS);
                wr_data  = req_q.ent[15:8] | 8'h01;
            end
            ST_WR_CHG: begin
                wr_valid = 1'b1;
                wr_addr  = base_addr + ADDR_W'(CHG_OFS);
                wr_data  = req_q.ent[7:0] | 8'h80;
            end
            ST_DONE:   res_valid = 1'b1;
            default:   ;
        endcase
    end

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R13

    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready); // R13

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R11

    AST_NO_WR_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !res_fault); // R10

    AST_CHG_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_addr[3:0] == 4'hF) |-> (req_q.acc == ACC_STORE)); // R11

    AST_FAULT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_fetch_cause != 3'b000 || res_data_cause != 3'b000)); // R8

    AST_STORE_GRANT_W: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault && req_q.acc == ACC_STORE) |-> res_perm[P_W]); // R7

    AST_NONSTORE_CHG: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault && req_q.acc != ACC_STORE && !req_q.ent[ENT_C_BIT])
        |-> !res_perm[P_W]); // R12

endmodule

// File: tb/test_pgperm_eval.sv
`timescale 1ns/1ps
module test_pgperm_eval;

    localparam int NK = 4;
    localparam int IW = 4;
    localparam int KW = 2;
    localparam int MW = 8;
    localparam int AW = IW + 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_priv = 1'b0;
    logic [1:0]    req_acc = 2'd0;
    logic          req_seg_kp = 1'b0;
    logic          req_seg_ks = 1'b0;
    logic          req_pp_hi = 1'b0;
    logic [15:0]   req_ent_low = 16'h0;
    logic [KW-1:0] req_key = '0;
    logic [IW-1:0] req_idx = '0;
    logic          amr_en = 1'b0;
    logic          iamr_en = 1'b0;
    logic [MW-1:0] amr = '0;
    logic [MW-1:0] iamr = '0;
    logic          res_valid;
    logic [2:0]    res_perm;
    logic          res_fault;
    logic [2:0]    res_fetch_cause;
    logic [2:0]    res_data_cause;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          wr_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pgperm_eval #(.NKEYS(NK), .IDX_W(IW)) i_pgperm_eval (
        .clk, .rst_n, .req_valid, .req_ready, .req_priv, .req_acc,
        .req_seg_kp, .req_seg_ks, .req_pp_hi, .req_ent_low, .req_key,
        .req_idx, .amr_en, .iamr_en, .amr, .iamr, .res_valid, .res_perm,
        .res_fault, .res_fetch_cause, .res_data_cause, .wr_valid,
        .wr_addr, .wr_data, .wr_ack
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] ref_code(input logic key, input logic [2:0] code);
        if (!key) begin
            if (code <= 3'd2) return 3'b111;            // R2
            if (code == 3'd3 || code == 3'd6) return 3'b101;
            return 3'b000;
        end
        if (code == 3'd2) return 3'b111;                 // R3
        if (code == 3'd1 || code == 3'd3) return 3'b101;
        return 3'b000;
    endfunction

    task automatic run_op(input logic priv, input logic [1:0] acc, input logic kp,
                          input logic ks, input logic pphi, input logic [15:0] ent,
                          input logic [KW-1:0] key, input logic [IW-1:0] idx,
                          input logic aen, input logic ien,
                          input logic [MW-1:0] am, input logic [MW-1:0] im);
        logic [2:0] cp, np, mp, fin, need;
        logic [1:0] df, ifl;
        logic       flt, cl, ml;
        logic [2:0] fc, dc;
        int         nw_exp, nw_got;
        int         ea [2];
        int         ed [2];
        bit         done;
        // expected values
        cp = ref_code(priv ? ks : kp, {pphi, ent[1:0]});                  // R1
        np = (ent[2] | ent[3]) ? 3'b110 : 3'b111;                          // R4
        mp = 3'b111;
        df = am[2*(NK-1-key) +: 2];
        ifl = im[2*(NK-1-key) +: 2];
        if (aen) begin                                                     // R5
            if (df[1]) mp[1] = 1'b0;
            if (df[0]) mp[2] = 1'b0;
            if (ien && ifl[0]) mp[0] = 1'b0;                               // R6
        end
        fin = cp & np & mp;                                                // R7
        need = (acc == 2'd0) ? 3'b001 : (acc == 2'd2) ? 3'b010 : 3'b100;
        flt = ((fin & need) == 3'b000);
        cl = ((cp & need) == 3'b000);
        ml = ((mp & need) == 3'b000);
        fc = 3'b000;
        dc = 3'b000;
        if (flt && acc == 2'd0) begin                                      // R8
            fc[0] = !np[0];
            fc[1] = np[0] && cl;
            fc[2] = ml;
        end
        if (flt && acc != 2'd0) begin                                      // R9
            dc[0] = cl;
            dc[1] = (acc == 2'd2);
            dc[2] = ml;
        end
        nw_exp = 0;
        if (!flt) begin
            if (!ent[8]) begin                                             // R10
                ea[nw_exp] = idx * 16 + 16;
                ed[nw_exp] = ent[15:8] | 8'h01;
                nw_exp++;
            end
            if (acc == 2'd2 && !ent[7]) begin                              // R11
                ea[nw_exp] = idx * 16 + 15;
                ed[nw_exp] = ent[7:0] | 8'h80;
                nw_exp++;
            end
            if (acc != 2'd2 && !ent[7]) fin[1] = 1'b0;                     // R12
        end
        // drive
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_priv = priv; req_acc = acc; req_seg_kp = kp; req_seg_ks = ks;
        req_pp_hi = pphi; req_ent_low = ent; req_key = key; req_idx = idx;
        amr_en = aen; iamr_en = ien; amr = am; iamr = im;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 busy ready", req_ready, 0);
        nw_got = 0;
        done = 0;
        for (int t = 0; t < 24 && !done; t++) begin
            if (t != 0) @(negedge clk);
            wr_ack = 1'b0;
            if (wr_valid) begin
                if (nw_got < nw_exp) begin
                    chk("R10 R11 write addr", wr_addr, ea[nw_got]);
                    chk("R10 R11 write data", wr_data, ed[nw_got]);
                end
                nw_got++;
                wr_ack = 1'b1;
            end
            if (res_valid) begin
                done = 1;
                chk("R7 perm", res_perm, fin);
                chk("R7 fault", res_fault, flt);
                chk("R8 fetch cause", res_fetch_cause, fc);
                chk("R9 data cause", res_data_cause, dc);
                chk("R10 R11 write count", nw_got, nw_exp);
            end
        end
        wr_ack = 1'b0;
        if (!done) chk("R13 result timeout", 0, 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R13 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset ready", req_ready, 1);
        chk("R13 reset res_valid", res_valid, 0);
        chk("R13 reset wr_valid", wr_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 idle ready", req_ready, 1);

        // sweep 1: code table, key select, attributes, usage bits
        for (int v = 0; v < 4096; v++) begin
            logic [15:0] e;
            e = 16'h0;
            e[1:0]   = v[1:0];
            e[2]     = v[5];
            e[3]     = v[6];
            e[7]     = v[7];
            e[8]     = v[8];
            e[6:4]   = 3'(v * 5);
            e[15:9]  = 7'(v * 3 + 1);
            run_op(v[9], v[4:3], v[10], v[11], v[2], e, KW'(v), IW'(v + 7),
                   1'b0, 1'b0, 8'hFF, 8'hFF);
        end

        // sweep 2: authority masks per key
        for (int k = 0; k < NK; k++)
            for (int f = 0; f < 4; f++)
                for (int ib = 0; ib < 2; ib++)
                    for (int en = 0; en < 4; en++)
                        for (int a = 0; a < 4; a++) begin
                            logic [MW-1:0] am, im;
                            am = '1;
                            im = '1;
                            am[2*(NK-1-k) +: 2] = 2'(f);
                            im[2*(NK-1-k) +: 2] = {1'b1, 1'(ib)};
                            run_op(1'b1, 2'(a), 1'b1, 1'b0, 1'b0, 16'h0182,
                                   KW'(k), IW'(k), en[0], en[1], am, im);
                        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule